// File: doc/BRIEF.md
# Neighbor Flag List Recorder

This block sits beside a bank of force pipelines and keeps a compact record of which source particles were close to which target particles. Once per board clock it receives a 48-bit neighbor flag vector, assembled from four pipeline sources of 12 flags each, together with the 17-bit index of the source particle in use that cycle. In any recording cycle where at least one flag is raised, it writes one 64-bit entry into an internal synchronous list memory and advances its write address. Cycles with no flag set leave the memory untouched, so the list only grows with real neighbor hits.

An entry keeps only the low 16 bits of the index. The source index never decreases during a run, so its top bit changes from 0 to 1 at most once. The block therefore captures the write address of the first stored entry whose top index bit is 1. The host rebuilds the full index of every entry from that single boundary value. A clear pulse starts a new list. A run level gates recording. After the run has ended, the host reads entries by address, together with the entry count, the boundary value and a sticky overflow flag.

A small control state machine sequences the block. Its states are IDLE, RECORD and FULL. Its transitions are START (IDLE to RECORD when run is seen), START_FULL (IDLE to FULL when run is seen while the list is full), FILL (RECORD to FULL on the write that takes the last slot), STOP (RECORD or FULL to IDLE when run is low) and CLEAR (any state to IDLE on a clear pulse).

Top module: `nbr_list_recorder`

## Requirements
- R1: In a cycle where the block is recording, the entry count rises by exactly one if any bit of the 48-bit flag vector is set. The vector is formed by four sources, each 12 bits wide.
- R2: A recording cycle with all 48 flags clear writes nothing and leaves the count unchanged.
- R3: A stored entry places the flag vector in bits 63:16 and the low 16 bits of the source index in bits 15:0.
- R4: Entries occupy consecutive addresses from 0 in the order of their cycles, and the count equals the number stored.
- R5: The boundary output equals the address of the first stored entry whose index bit 16 is 1. Later such entries do not move it. While no such entry has been stored, the boundary output equals the entry count.
- R6: With the count at the list depth, further flagged cycles are dropped: the count stays at the depth, stored entries are unchanged, and the overflow flag is set and stays set.
- R7: A clear pulse sets the count to 0, makes the boundary unset (equal to the count) and clears overflow. Clear takes priority over run and returns the machine to IDLE.
- R8: Recording starts on the cycle after run is first seen high in IDLE, so flags in that first cycle are not stored. No cycle with run low stores anything.
- R9: While idle with run low, a read request with an address at one clock edge presents that entry on the read data port after that edge. A read request while run is high is ignored, and the read data holds its value.
- R10: After reset the count, boundary and overflow are 0, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low reset |
| run_i | input | 1 | Recording enable level |
| clear_i | input | 1 | Start-of-list clear pulse |
| flags_i | input | 48 | Neighbor flags, four sources of 12 |
| pidx_i | input | 17 | Source particle index of this cycle |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | 64 | Entry read back |
| entry_count_o | output | ADDR_W+1 | Number of stored entries |
| msb_mark_o | output | ADDR_W+1 | Address of the first entry with index bit 16 set |
| overflow_o | output | 1 | Sticky dropped-entry flag |

## Verification
The checker watches, on every cycle, that the count never passes the depth and only holds or steps by one. It also checks that the count holds whenever flags are clear or run is low, that a clear zeroes the count, the boundary and the overflow flag, that overflow is sticky, that the boundary never exceeds the count, and that the read data is frozen while run is high. Entry contents and field placement, arrival order, the exact address captured at the index crossing, the dropped start cycle, and the intactness of the list after overflow need the bench's scenarios. The bench reads the list back and compares it with its own model.

// File: rtl/nl_pkg.sv
package nl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECORD = 2'd1,
        ST_FULL   = 2'd2
    } nl_state_e;

endpackage

// File: rtl/nl_flag_merge.sv
module nl_flag_merge #(
    parameter int NUM_SRC       = 4,
    parameter int FLAGS_PER_SRC = 12,
    localparam int FLAG_W       = NUM_SRC * FLAGS_PER_SRC
) (
    input  logic [FLAG_W-1:0] flags_i,
    output logic              any_o
);

    logic [NUM_SRC-1:0] src_any;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_any[s] = |flags_i[s*FLAGS_PER_SRC +: FLAGS_PER_SRC];
    end

    assign any_o = |src_any;

endmodule

// File: rtl/nl_ctrl_fsm.sv
module nl_ctrl_fsm
    import nl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    input  logic any_i,
    input  logic full_i,
    input  logic last_i,
    output logic wr_en_o,
    output logic drop_o,
    output logic rd_ok_o
);

    nl_state_e state_q;
    nl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clear_i) begin
                    state_d = ST_IDLE;
                end else if (run_i) begin
                    state_d = full_i ? ST_FULL : ST_RECORD;
                end
            end
            ST_RECORD: begin
                if (clear_i || !run_i) begin
                    state_d = ST_IDLE;
                end else if (any_i && last_i) begin
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (clear_i || !run_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en_o = (state_q == ST_RECORD) && run_i && !clear_i && any_i;
        drop_o  = (state_q == ST_FULL) && run_i && !clear_i && any_i;
        rd_ok_o = (state_q == ST_IDLE) && !run_i;
    end

endmodule

// File: rtl/nl_list_tracker.sv
module nl_list_tracker #(
    parameter int ADDR_W = 11,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic              drop_i,
    input  logic              idx_msb_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              last_o,
    output logic [CNT_W-1:0]  mark_o,
    output logic              overflow_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [CNT_W-1:0] LAST_C  = {1'b0, {ADDR_W{1'b1}}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] mark_q;
    logic             mark_set_q;
    logic             ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q    <= '0;
            mark_q     <= '0;
            mark_set_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else if (clear_i) begin
            count_q    <= '0;
            mark_q     <= '0;
            mark_set_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            if (wr_en_i) begin
                count_q <= count_q + 1'b1;
                if (idx_msb_i && !mark_set_q) begin
                    mark_q     <= count_q;
                    mark_set_q <= 1'b1;
                end
            end
            if (drop_i) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign wr_addr_o  = count_q[ADDR_W-1:0];
    assign count_o    = count_q;
    assign full_o     = (count_q == DEPTH_C);
    assign last_o     = (count_q == LAST_C);
    assign mark_o     = mark_set_q ? mark_q : count_q;
    assign overflow_o = ovf_q;

endmodule

// File: rtl/nl_list_store.sv
module nl_list_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 64,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_raw;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
        if (rd_en_i) begin
            rd_raw <= mem_q[rd_addr_i];
        end
    end

    logic rd_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_seen_q <= 1'b0;
        end else if (rd_en_i) begin
            rd_seen_q <= 1'b1;
        end
    end

    assign rd_data_o = rd_seen_q ? rd_raw : '0;

endmodule

// File: rtl/nbr_list_recorder.sv
module nbr_list_recorder #(
    parameter int NUM_SRC       = 4,
    parameter int FLAGS_PER_SRC = 12,
    parameter int IDX_W         = 17,
    parameter int ADDR_W        = 11,
    localparam int FLAG_W       = NUM_SRC * FLAGS_PER_SRC,
    localparam int DATA_W       = FLAG_W + IDX_W - 1,
    localparam int CNT_W        = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [IDX_W-1:0]  pidx_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  entry_count_o,
    output logic [CNT_W-1:0]  msb_mark_o,
    output logic              overflow_o
);

    logic              any_flag;
    logic              wr_en;
    logic              drop;
    logic              rd_ok;
    logic              full;
    logic              last;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] entry;

    assign entry = {flags_i, pidx_i[IDX_W-2:0]};

    nl_flag_merge #(
        .NUM_SRC       (NUM_SRC),
        .FLAGS_PER_SRC (FLAGS_PER_SRC)
    ) merge_i (
        .flags_i (flags_i),
        .any_o   (any_flag)
    );

    nl_ctrl_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .clear_i (clear_i),
        .any_i   (any_flag),
        .full_i  (full),
        .last_i  (last),
        .wr_en_o (wr_en),
        .drop_o  (drop),
        .rd_ok_o (rd_ok)
    );

    nl_list_tracker #(
        .ADDR_W (ADDR_W)
    ) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (wr_en),
        .drop_i     (drop),
        .idx_msb_i  (pidx_i[IDX_W-1]),
        .wr_addr_o  (wr_addr),
        .count_o    (entry_count_o),
        .full_o     (full),
        .last_o     (last),
        .mark_o     (msb_mark_o),
        .overflow_o (overflow_o)
    );

    nl_list_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (entry),
        .rd_en_i   (rd_en_i && rd_ok),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/nl_recorder_chk.sv
module nl_recorder_chk #(
    parameter int ADDR_W = 11,
    parameter int FLAG_W = 48,
    parameter int DATA_W = 64,
    localparam int CNT_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              clear_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [CNT_W-1:0]  entry_count_o,
    input logic [CNT_W-1:0]  msb_mark_o,
    input logic              overflow_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE_C   = {{ADDR_W{1'b0}}, 1'b1};

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count_o <= DEPTH_C); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (entry_count_o == $past(entry_count_o)) ||
                     (entry_count_o == $past(entry_count_o) + ONE_C)); // R1

    AST_NO_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && flags_i == '0) |=> $stable(entry_count_o)); // R2

    AST_RUN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !run_i) |=> $stable(entry_count_o)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (entry_count_o == '0 && msb_mark_o == '0 && !overflow_o)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clear_i) |=> overflow_o); // R6

    AST_MARK_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        msb_mark_o <= entry_count_o); // R5

    AST_RD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(rd_data_o)); // R9

endmodule

bind nbr_list_recorder nl_recorder_chk #(
    .ADDR_W (ADDR_W),
    .FLAG_W (FLAG_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_i),
    .clear_i       (clear_i),
    .flags_i       (flags_i),
    .rd_data_o     (rd_data_o),
    .entry_count_o (entry_count_o),
    .msb_mark_o    (msb_mark_o),
    .overflow_o    (overflow_o)
);

// File: tb/nbr_list_recorder_tb_top.sv
`timescale 1ns/1ps
module nbr_list_recorder_tb_top;

    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [47:0]   flags_i = '0;
    logic [16:0]   pidx_i = '0;
    logic          rd_en_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [63:0]   rd_data_o;
    logic [AW:0]   entry_count_o;
    logic [AW:0]   msb_mark_o;
    logic          overflow_o;

    always #4 clk = ~clk;

    nbr_list_recorder #(.ADDR_W(AW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .clear_i       (clear_i),
        .flags_i       (flags_i),
        .pidx_i        (pidx_i),
        .rd_en_i       (rd_en_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .entry_count_o (entry_count_o),
        .msb_mark_o    (msb_mark_o),
        .overflow_o    (overflow_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_rec = 1'b0;
    int          m_cnt = 0;
    int          m_mark = 0;
    bit          m_mark_set = 1'b0;
    bit          m_ovf = 1'b0;
    logic [63:0] m_mem [DEPTH];

    function automatic int exp_mark();
        return m_mark_set ? m_mark : m_cnt;
    endfunction

    function automatic logic [47:0] rnd_flags();
        logic [63:0] t;
        case ($urandom_range(3))
            0: return '0;
            1: begin
                t = 64'(12'($urandom) | 12'h001);
                return 48'(t << (12 * $urandom_range(3)));
            end
            default: begin
                t = {$urandom, $urandom};
                return t[47:0];
            end
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (clear_i) begin
            m_rec = 1'b0; m_cnt = 0; m_mark_set = 1'b0; m_ovf = 1'b0;
        end else if (!m_rec) begin
            if (run_i) m_rec = 1'b1;
        end else if (!run_i) begin
            m_rec = 1'b0;
        end else if (|flags_i) begin
            if (m_cnt < DEPTH) begin
                m_mem[m_cnt] = {flags_i, pidx_i[15:0]};
                if (pidx_i[16] && !m_mark_set) begin
                    m_mark = m_cnt; m_mark_set = 1'b1;
                end
                m_cnt++;
            end else begin
                m_ovf = 1'b1;
            end
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic status(string req);
        chk(req, 64'(entry_count_o), 64'(m_cnt), "count");
        chk(req, 64'(msb_mark_o), 64'(exp_mark()), "mark");
        chk(req, 64'(overflow_o), 64'(m_ovf), "overflow");
    endtask

    task automatic read_chk(int addr, string req);
        rd_en_i = 1'b1; rd_addr_i = AW'(addr); flags_i = '0;
        tick();
        rd_en_i = 1'b0;
        chk(req, rd_data_o, m_mem[addr], $sformatf("entry %0d", addr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [16:0] idx;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", 64'(entry_count_o), 0, "count");
        chk("R10", 64'(msb_mark_o), 0, "mark");
        chk("R10", 64'(overflow_o), 0, "overflow");
        chk("R10", rd_data_o, 0, "rd_data");

        // R8: flags in the cycle run is first seen are not stored
        run_i = 1'b1; flags_i = 48'hFFF; pidx_i = 17'h0_0005;
        tick();
        chk("R8", 64'(entry_count_o), 0, "count after start cycle");

        // R1 R2 R5: random stream crossing the index MSB
        idx = 17'h0_FFF6;
        for (int k = 0; k < 24; k++) begin
            flags_i = rnd_flags();
            pidx_i = idx;
            tick();
            chk("R1", 64'(entry_count_o), 64'(m_cnt), "count step");
            idx = idx + 17'(1 + $urandom_range(1));
        end
        flags_i = '0;
        tick();
        chk("R2", 64'(entry_count_o), 64'(m_cnt), "count on clear flags");
        status("R5");

        // R8: run low stores nothing
        run_i = 1'b0; flags_i = 48'h800_000_000_001; pidx_i = idx;
        tick();
        tick();
        chk("R8", 64'(entry_count_o), 64'(m_cnt), "count with run low");

        // R3 R4: read back the list
        for (int a = 0; a < m_cnt; a++) begin
            read_chk(a, "R4");
        end
        if (m_cnt > 0) begin
            read_chk(0, "R3");
        end

        // R9: read ignored while run is high
        held = rd_data_o;
        run_i = 1'b1; flags_i = '0;
        tick();
        rd_en_i = 1'b1; rd_addr_i = AW'(m_cnt - 1);
        tick();
        rd_en_i = 1'b0;
        chk("R9", rd_data_o, held, "rd_data during run");
        run_i = 1'b0;
        tick();

        // R7: clear with run high wins
        clear_i = 1'b1; run_i = 1'b1; flags_i = 48'h1;
        tick();
        clear_i = 1'b0;
        status("R7");

        // R6: fill beyond depth with low indices (R5 unset)
        for (int k = 0; k < DEPTH + 8; k++) begin
            flags_i = rnd_flags() | 48'h1;
            pidx_i = 17'(k);
            tick();
        end
        chk("R6", 64'(entry_count_o), 64'(DEPTH), "count at depth");
        chk("R6", 64'(overflow_o), 1, "overflow");
        chk("R5", 64'(msb_mark_o), 64'(DEPTH), "mark unset");
        run_i = 1'b0; flags_i = '0;
        tick();
        tick();
        chk("R6", 64'(overflow_o), 1, "overflow sticky");
        read_chk(0, "R6");
        read_chk(DEPTH - 1, "R6");

        // R7: clear drops overflow
        clear_i = 1'b1;
        tick();
        clear_i = 1'b0;
        status("R7");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule